// File: doc/BRIEF.md
# Serial Link Command Slot Receiver

This block sits on the codec side of an AC'97-style serial link. It receives the outbound serial data stream one bit per bit-clock cycle and uses rising edges of the frame sync line to align itself to frame boundaries. Each frame is 256 bits long: a 16-bit tag slot followed by twelve 20-bit slots. The block reads the command slot (slot 1) and the data slot (slot 2). It decodes whether the command is a read or a write, and which register it targets. It then acts on a local file of 16-bit control registers.

A write needs the tag to mark both slot 1 and slot 2 as valid, and it updates the addressed register. A read needs only slot 1 to be valid. The block fetches the addressed register and, for exactly one frame starting with the next frame, presents the echoed index and the register contents on a parallel response port. A separate inbound-frame serializer picks the response up from there. Only even indices hold registers. Odd indices are reserved: a write to one changes nothing, and a read of one returns zero.

Top module: `aclink_cmd_port`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every register reads back the default word 16'h0A5A until it is written.
- R2: A command with tag bit 14 (slot 1 valid) and tag bit 13 (slot 2 valid) both set, and slot 1 bit 19 = 0, writes the data to the register at the indexed even location; a later read returns that value.
- R3: A write command whose tag has slot 2 marked not valid (tag bit 13 = 0) leaves the register unchanged.
- R4: A write to an odd index changes no register, including the even register sharing the same upper index bits.
- R5: A read of an odd index produces a response with that index echoed and data 16'h0000.
- R6: A read command (slot 1 bit 19 = 1) whose tag has slot 1 marked not valid (tag bit 14 = 0) produces no response.
- R7: A read response is asserted from the start of the frame that follows the read command, and it is withdrawn at the start of the frame after that.
- R8: Bits are taken MSB first. In slot 1, bit 19 is the read flag and bits 18:12 are the index. Slot 2 bits 19:4 are the write data. The slot 1 bits 11:0 and the slot 2 bits 3:0 are ignored.
- R9: A rising edge of `sync` restarts the bit count, so a frame that follows a truncated frame is decoded correctly.
- R10: Reset discards a read response that is still pending and restores every register to its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; serial data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync; a rising edge marks bit 0 of a frame |
| sdo | input | 1 | Outbound serial data stream |
| rsp_valid | output | 1 | Read response present for the current frame |
| rsp_index | output | 7 | Index echoed from the read command |
| rsp_data | output | 16 | Register contents returned by the read |

## Verification
A register file that is wrong internally shows up only through the read path. A lost write, a write that lands in the wrong location, or a default that is not restored after reset appears as wrong `rsp_data` in the frame that follows the read. That is about 256 clocks after the command. A slot counter that has slipped shows up at once as misdecoded fields: a wrong echoed index, shifted data, or a missing response. A stale pending flag shows up as `rsp_valid` held for a second frame.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int IDX_W  = 7;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              s1_ok;
    logic              s2_ok;
    logic              is_rd;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] wdata;
  } cmd_t;
endpackage

// File: rtl/aclink_deser.sv
module aclink_deser
  import aclink_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic sync,
  input  logic sdo,
  output logic frame_start,
  output logic cmd_stb,
  output cmd_t cmd
);
  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int CAP_W     = TAG_W + 2 * SLOT_W;
  localparam logic [CNT_W-1:0] CAP_POS  = CNT_W'(CAP_W - 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  logic             sync_q, locked;
  logic [CNT_W-1:0] cnt_q, pos;
  logic [CAP_W-2:0] shreg;
  logic [CAP_W-1:0] word;
  logic             sync_rise, active;
  logic [TAG_W-1:0] tag;
  logic [SLOT_W-1:0] slot1, slot2;

  always_comb begin
    sync_rise = sync & ~sync_q;
    active    = locked | sync_rise;
    pos       = sync_rise ? '0 : cnt_q;
    word      = {shreg, sdo};
    tag       = word[CAP_W-1 -: TAG_W];
    slot1     = word[2*SLOT_W-1 -: SLOT_W];
    slot2     = word[SLOT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= 1'b0;
      locked      <= 1'b0;
      cnt_q       <= '0;
      shreg       <= '0;
      frame_start <= 1'b0;
      cmd_stb     <= 1'b0;
      cmd         <= '0;
    end else begin
      sync_q      <= sync;
      cmd_stb     <= 1'b0;
      frame_start <= active && (pos == '0);
      if (active) begin
        locked <= 1'b1;
        cnt_q  <= (pos == LAST_POS) ? '0 : CNT_W'(pos + 1'b1);
        shreg  <= word[CAP_W-2:0];
        if (pos == CAP_POS) begin
          cmd_stb   <= 1'b1;
          cmd.s1_ok <= tag[TAG_W-2];
          cmd.s2_ok <= tag[TAG_W-3];
          cmd.is_rd <= slot1[SLOT_W-1];
          cmd.idx   <= slot1[SLOT_W-2 -: IDX_W];
          cmd.wdata <= slot2[SLOT_W-1 -: WORD_W];
        end
      end
    end
  end

  // R9
  single_stb_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);

  // R7
  frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
endmodule

// File: rtl/aclink_regfile.sv
module aclink_regfile #(
  parameter int              DEPTH = 64,
  parameter int              DW    = 16,
  parameter logic [DW-1:0]   DFLT  = 16'h0A5A,
  localparam int             AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] wr_flag;
  logic [DW-1:0]    rd_q;
  logic             rflag_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rd_q <= mem[raddr];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) wr_flag[i] <= 1'b0;
      else if (we && waddr == AW'(i)) wr_flag[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rflag_q <= 1'b0;
    else if (re) rflag_q <= wr_flag[raddr];
  end

  assign rdata = rflag_q ? rd_q : DFLT;

  // R1
  flags_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (wr_flag == '0));
endmodule

// File: rtl/aclink_cmd_port.sv
module aclink_cmd_port
  import aclink_pkg::*;
#(
  parameter int                 TAG_W     = 16,
  parameter int                 SLOT_W    = 20,
  parameter int                 NUM_SLOTS = 12,
  parameter logic [WORD_W-1:0]  DFLT      = 16'h0A5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync,
  input  logic              sdo,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [WORD_W-1:0] rsp_data
);
  localparam int NREG = 2 ** (IDX_W - 1);
  localparam int AW   = IDX_W - 1;

  logic            frame_start, cmd_stb;
  cmd_t            cmd;
  logic            wr_en, rd_en, rd_q, odd_q, pend_q;
  logic [AW-1:0]   addr;
  logic [WORD_W-1:0] rdata, pend_data;
  logic [IDX_W-1:0]  pend_idx;

  aclink_deser #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_deser (
    .clk(clk), .rst(rst), .sync(sync), .sdo(sdo),
    .frame_start(frame_start), .cmd_stb(cmd_stb), .cmd(cmd)
  );

  always_comb begin
    addr  = cmd.idx[IDX_W-1:1];
    wr_en = cmd_stb && cmd.s1_ok && cmd.s2_ok && !cmd.is_rd && !cmd.idx[0];
    rd_en = cmd_stb && cmd.s1_ok && cmd.is_rd;
  end

  aclink_regfile #(.DEPTH(NREG), .DW(WORD_W), .DFLT(DFLT)) u_regs (
    .clk(clk), .rst(rst),
    .we(wr_en), .waddr(addr), .wdata(cmd.wdata),
    .re(rd_en), .raddr(addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      odd_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      rsp_valid <= 1'b0;
      rsp_index <= '0;
      rsp_data  <= '0;
    end else begin
      rd_q <= rd_en;
      if (rd_en) begin
        pend_idx <= cmd.idx;
        odd_q    <= cmd.idx[0];
      end
      if (frame_start) begin
        rsp_valid <= pend_q;
        rsp_index <= pend_q ? pend_idx : '0;
        rsp_data  <= pend_q ? pend_data : '0;
        pend_q    <= 1'b0;
      end
      if (rd_q) begin
        pend_q    <= 1'b1;
        pend_data <= odd_q ? '0 : rdata;
      end
    end
  end

  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(rsp_valid));

  // R5
  odd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_index[0]) |-> (rsp_data == '0));

  // R4
  odd_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd.idx[0]) |-> !wr_en);

  // R10
  reset_rsp_chk: assert property (@(posedge clk)
    $past(rst) |-> !rsp_valid);
endmodule

// File: tb/test_aclink_cmd_port.sv
module test_aclink_cmd_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync = 1'b0;
  logic        sdo = 1'b0;
  logic        rsp_valid;
  logic [6:0]  rsp_index;
  logic [15:0] rsp_data;

  localparam logic [15:0] DFLT_EXP = 16'h0A5A;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit          mid_v;
  logic [6:0]  mid_i;
  logic [15:0] mid_d;

  always #4 clk = ~clk;

  aclink_cmd_port i_aclink_cmd_port (
    .clk(clk), .rst(rst), .sync(sync), .sdo(sdo),
    .rsp_valid(rsp_valid), .rsp_index(rsp_index), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, input logic [19:0] s2);
    logic [255:0] fr;
    fr = '0;
    fr[255 -: 16] = tag;
    fr[239 -: 20] = s1;
    fr[219 -: 20] = s2;
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      sync = (b < 16);
      sdo  = fr[255-b];
      if (b == 128) begin
        mid_v = rsp_valid; mid_i = rsp_index; mid_d = rsp_data;
      end
    end
  endtask

  task automatic wr(input logic [6:0] idx, input logic [15:0] d, input logic [15:0] tag = 16'hE000,
                    input logic [11:0] rsv = 12'h000, input logic [3:0] lo = 4'h0);
    send_frame(tag, {1'b0, idx, rsv}, {d, lo});
  endtask

  task automatic rd(input logic [6:0] idx, output bit v, output logic [6:0] ri,
                    output logic [15:0] rdv, output bit v_after, input logic [15:0] tag = 16'hC000);
    send_frame(tag, {1'b1, idx, 12'h000}, 20'h0);
    send_frame(16'h0, 20'h0, 20'h0);
    v = mid_v; ri = mid_i; rdv = mid_d;
    send_frame(16'h0, 20'h0, 20'h0);
    v_after = mid_v;
  endtask

  task automatic t_reset;
    bit v, va; logic [6:0] i; logic [15:0] d;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    rd(7'h02, v, i, d, va);
    chk(v && d == DFLT_EXP, "R1 default value", d, DFLT_EXP);
  endtask

  task automatic t_write_read;
    bit v, va; logic [6:0] i; logic [15:0] d;
    wr(7'h04, 16'h1234);
    wr(7'h7E, 16'hBEEF);
    rd(7'h04, v, i, d, va);
    chk(v && i == 7'h04 && d == 16'h1234, "R2 write/read idx04", d, 16'h1234);
    rd(7'h7E, v, i, d, va);
    chk(v && i == 7'h7E && d == 16'hBEEF, "R2 write/read idx7E", d, 16'hBEEF);
  endtask

  task automatic t_timing;
    bit v, va; logic [6:0] i; logic [15:0] d;
    send_frame(16'hC000, {1'b1, 7'h04, 12'h0}, 20'h0);
    chk(mid_v == 1'b0, "R7 no response in command frame", mid_v, 0);
    send_frame(16'h0, 20'h0, 20'h0);
    chk(mid_v == 1'b1 && mid_d == 16'h1234, "R7 response in next frame", mid_d, 16'h1234);
    send_frame(16'h0, 20'h0, 20'h0);
    chk(mid_v == 1'b0, "R7 response withdrawn after one frame", mid_v, 0);
  endtask

  task automatic t_no_slot2;
    bit v, va; logic [6:0] i; logic [15:0] d;
    wr(7'h04, 16'hDEAD, 16'hC000);
    rd(7'h04, v, i, d, va);
    chk(v && d == 16'h1234, "R3 write without slot2 valid ignored", d, 16'h1234);
  endtask

  task automatic t_odd;
    bit v, va; logic [6:0] i; logic [15:0] d;
    wr(7'h05, 16'h5555);
    rd(7'h04, v, i, d, va);
    chk(v && d == 16'h1234, "R4 odd write leaves even neighbour", d, 16'h1234);
    rd(7'h05, v, i, d, va);
    chk(v && i == 7'h05, "R5 odd read echoes index", i, 7'h05);
    chk(d == 16'h0000, "R5 odd read returns zero", d, 0);
  endtask

  task automatic t_no_slot1;
    bit v, va; logic [6:0] i; logic [15:0] d;
    rd(7'h04, v, i, d, va, 16'h8000);
    chk(v == 1'b0, "R6 read without slot1 valid ignored", v, 0);
  endtask

  task automatic t_fields;
    bit v, va; logic [6:0] i; logic [15:0] d;
    wr(7'h2A, 16'h8001, 16'hE000, 12'hFFF, 4'hF);
    rd(7'h2A, v, i, d, va);
    chk(v && i == 7'h2A && d == 16'h8001, "R8 field positions, reserved bits ignored", d, 16'h8001);
  endtask

  task automatic t_realign;
    bit v, va; logic [6:0] i; logic [15:0] d;
    for (int b = 0; b < 103; b++) begin
      @(negedge clk);
      sync = (b < 3);
      sdo  = 1'b0;
    end
    wr(7'h10, 16'h0F0F);
    rd(7'h10, v, i, d, va);
    chk(v && i == 7'h10 && d == 16'h0F0F, "R9 realign after short frame", d, 16'h0F0F);
  endtask

  task automatic t_reset_pending;
    bit v, va; logic [6:0] i; logic [15:0] d;
    send_frame(16'hC000, {1'b1, 7'h04, 12'h0}, 20'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(rsp_valid == 1'b0, "R10 no response right after reset", rsp_valid, 0);
    send_frame(16'h0, 20'h0, 20'h0);
    chk(mid_v == 1'b0, "R10 pending read discarded", mid_v, 0);
    rd(7'h04, v, i, d, va);
    chk(v && d == DFLT_EXP, "R10 register default restored", d, DFLT_EXP);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_timing();
    t_no_slot2();
    t_odd();
    t_no_slot1();
    t_fields();
    t_realign();
    t_reset_pending();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule